// File: doc/BRIEF.md
# Serial Divider Programming Interface

This block takes configuration words for a frequency synthesizer over a three-wire serial port made of a data line, a serial clock and a load strobe. All three lines are brought into the system clock domain through two-flop synchronisers. On each rising edge of the synchronised serial clock, one data bit enters a single shift register. The most significant bit arrives first.

A rising edge on the load strobe copies the most recent bits into one of two holding registers. The last bit shifted in is a routing bit, and it picks the destination.

- **Reference word (16 bits):** a prescaler modulus select bit and a 14-bit reference ratio.
- **Main word (19 bits):** an 11-bit main count and a 7-bit swallow count.

A word whose decoded ratio falls in the prohibited range is dropped. The held values stay as they were, and a one-cycle error pulse is raised. While the synchronised load strobe is high, a fast-lock enable output is also held high. The held values feed the divider counters downstream.

Top module: `serial_div_cfg`

## Requirements
- R1: After reset the outputs are ref_ratio_o=8, mod_sel_o=0, main_cnt_o=16, swal_cnt_o=0, fast_lock_o=0 and cfg_err_o=0.
- R2: Each rising edge of ser_clk_i shifts the value of ser_dat_i into the shift register. Words are sent most significant bit first, and the routing bit is sent last.
- R3: A load with routing bit 1 takes a 16-bit word, first bit to last: mod_sel, then ratio bit 13 down to bit 0, then the routing bit. It updates ref_ratio_o and mod_sel_o, where mod_sel_o=1 means modulus 64 and 0 means 128. The main outputs are left unchanged.
- R4: A load with routing bit 0 takes a 19-bit word, first bit to last: main count bit 10 down to bit 0, then swallow bit 6 down to bit 0, then the routing bit. It updates main_cnt_o and swal_cnt_o. The reference outputs are left unchanged.
- R5: The held outputs change only on a rising edge of the synchronised ser_le_i. Shifting bits without a load leaves every held output unchanged.
- R6: A reference load with a ratio below 8 is rejected. The reference outputs keep their previous values, and cfg_err_o is high for exactly one cycle.
- R7: A main load with a main count below 16 is rejected. The main outputs keep their previous values, and cfg_err_o is high for exactly one cycle.
- R8: fast_lock_o equals ser_le_i delayed by two system clock edges.
- R9: Only the most recent 16 bits (reference word) or 19 bits (main word) are used. Any bits shifted in before them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous |
| ref_ratio_o | output | 14 | Held reference divide ratio |
| mod_sel_o | output | 1 | Held prescaler select, 1 = 64, 0 = 128 |
| main_cnt_o | output | 11 | Held main count |
| swal_cnt_o | output | 7 | Held swallow count |
| fast_lock_o | output | 1 | Fast-lock switch enable |
| cfg_err_o | output | 1 | One-cycle pulse when a load is rejected |

## Verification
A fault in the shift register or the field decode shows up as wrong held values one system cycle after the synchronised load edge. That is three clock edges after ser_le_i rises. A wrong routing decision shows up as a change on the outputs of the latch that should not have been touched. A fault in the range check shows up either as a missing or doubled error pulse, or as a prohibited value reaching the outputs. The fast-lock output shows a faulty synchroniser at once, because its level is checked both one edge and two edges after the strobe rises.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  typedef enum logic {
    ROUTE_MAIN = 1'b0,
    ROUTE_REF  = 1'b1
  } route_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '0;
      else         pipe <= {pipe[STAGES-1:0], async_i[g]};
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned SR_W = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [SR_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[SR_W-2:0], bit_i};
  end
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import serial_cfg_pkg::*;
#(
  parameter int unsigned REF_W    = 14,
  parameter int unsigned SWAL_W   = 7,
  parameter int unsigned MAIN_W   = 11,
  parameter int unsigned REF_MIN  = 8,
  parameter int unsigned MAIN_MIN = 16,
  parameter int unsigned SR_W     = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SR_W-1:0]   word_i,
  output logic [REF_W-1:0]  ref_ratio_o,
  output logic              mod_sel_o,
  output logic [MAIN_W-1:0] main_cnt_o,
  output logic [SWAL_W-1:0] swal_cnt_o,
  output logic              err_o
);
  localparam int unsigned MAIN_LSB = SWAL_W + 1;
  localparam int unsigned MAIN_MSB = SWAL_W + MAIN_W;

  route_e              route;
  logic                new_mod;
  logic [REF_W-1:0]    new_ratio;
  logic [MAIN_W-1:0]   new_main;
  logic [SWAL_W-1:0]   new_swal;
  logic                ref_ok, main_ok;

  always_comb begin
    route     = route_e'(word_i[0]);
    new_mod   = word_i[REF_W+1];
    new_ratio = word_i[REF_W:1];
    new_swal  = word_i[SWAL_W:1];
    new_main  = word_i[MAIN_MSB:MAIN_LSB];
    ref_ok    = new_ratio >= REF_W'(REF_MIN);
    main_ok   = new_main  >= MAIN_W'(MAIN_MIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_ratio_o <= REF_W'(REF_MIN);
      mod_sel_o   <= 1'b0;
      main_cnt_o  <= MAIN_W'(MAIN_MIN);
      swal_cnt_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (load_i) begin
        if (route == ROUTE_REF) begin
          if (ref_ok) begin
            ref_ratio_o <= new_ratio;
            mod_sel_o   <= new_mod;
          end else begin
            err_o <= 1'b1;
          end
        end else begin
          if (main_ok) begin
            main_cnt_o <= new_main;
            swal_cnt_o <= new_swal;
          end else begin
            err_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_div_cfg.sv
module serial_div_cfg
  import serial_cfg_pkg::*;
#(
  parameter int unsigned REF_W    = 14,
  parameter int unsigned SWAL_W   = 7,
  parameter int unsigned MAIN_W   = 11,
  parameter int unsigned REF_MIN  = 8,
  parameter int unsigned MAIN_MIN = 16,
  parameter int unsigned STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  output logic [REF_W-1:0]  ref_ratio_o,
  output logic              mod_sel_o,
  output logic [MAIN_W-1:0] main_cnt_o,
  output logic [SWAL_W-1:0] swal_cnt_o,
  output logic              fast_lock_o,
  output logic              cfg_err_o
);
  localparam int unsigned REF_WORD  = REF_W + 2;
  localparam int unsigned MAIN_WORD = MAIN_W + SWAL_W + 1;
  localparam int unsigned SR_W      = max_u(REF_WORD, MAIN_WORD);

  localparam int unsigned IDX_CLK = 0;
  localparam int unsigned IDX_DAT = 1;
  localparam int unsigned IDX_LE  = 2;

  logic [2:0]      sync_lvl, sync_rise;
  logic [SR_W-1:0] sr_word;

  cfg_sync #(.W(3), .STAGES(STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_le_i, ser_dat_i, ser_clk_i}),
    .lvl_o   (sync_lvl),
    .rise_o  (sync_rise)
  );

  cfg_shifter #(.SR_W(SR_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sync_rise[IDX_CLK]),
    .bit_i   (sync_lvl[IDX_DAT]),
    .word_o  (sr_word)
  );

  cfg_latch #(
    .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
    .REF_MIN(REF_MIN), .MAIN_MIN(MAIN_MIN), .SR_W(SR_W)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sync_rise[IDX_LE]),
    .word_i      (sr_word),
    .ref_ratio_o (ref_ratio_o),
    .mod_sel_o   (mod_sel_o),
    .main_cnt_o  (main_cnt_o),
    .swal_cnt_o  (swal_cnt_o),
    .err_o       (cfg_err_o)
  );

  assign fast_lock_o = sync_lvl[IDX_LE];
endmodule

// File: rtl/serial_div_cfg_chk.sv
module serial_div_cfg_chk #(
  parameter int unsigned REF_W    = 14,
  parameter int unsigned SWAL_W   = 7,
  parameter int unsigned MAIN_W   = 11,
  parameter int unsigned REF_MIN  = 8,
  parameter int unsigned MAIN_MIN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_le_i,
  input logic [REF_W-1:0]  ref_ratio_o,
  input logic              mod_sel_o,
  input logic [MAIN_W-1:0] main_cnt_o,
  input logic [SWAL_W-1:0] swal_cnt_o,
  input logic              fast_lock_o,
  input logic              cfg_err_o
);
  // R5: no load edge in the previous cycle, no change now
  a_r5_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(fast_lock_o) |=> ($stable(ref_ratio_o) && $stable(mod_sel_o)
                             && $stable(main_cnt_o) && $stable(swal_cnt_o)));

  a_r6_ratio_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ratio_o >= REF_W'(REF_MIN));

  a_r7_main_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_cnt_o >= MAIN_W'(MAIN_MIN));

  a_r6_err_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !cfg_err_o);

  a_r7_err_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> ($stable(ref_ratio_o) && $stable(mod_sel_o)
                   && $stable(main_cnt_o) && $stable(swal_cnt_o)));

  a_r8_err_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> fast_lock_o);
endmodule

bind serial_div_cfg serial_div_cfg_chk #(
  .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
  .REF_MIN(REF_MIN), .MAIN_MIN(MAIN_MIN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_le_i    (ser_le_i),
  .ref_ratio_o (ref_ratio_o),
  .mod_sel_o   (mod_sel_o),
  .main_cnt_o  (main_cnt_o),
  .swal_cnt_o  (swal_cnt_o),
  .fast_lock_o (fast_lock_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/serial_div_cfg_test.sv
module serial_div_cfg_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic        mod_sel;
  logic [10:0] main_cnt;
  logic [6:0]  swal_cnt;
  logic        fast_lock, cfg_err;

  int n_chk = 0, n_bad = 0, err_seen = 0;
  int e_ratio = 8, e_mod = 0, e_main = 16, e_swal = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_div_cfg uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
    .ref_ratio_o(ref_ratio), .mod_sel_o(mod_sel),
    .main_cnt_o(main_cnt), .swal_cnt_o(swal_cnt),
    .fast_lock_o(fast_lock), .cfg_err_o(cfg_err)
  );

  always @(posedge clk) if (rst_ni && cfg_err) err_seen++;

  // kind 1: reference (a = mod_sel, b = ratio); kind 0: main (a = main, b = swallow)
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{1, 1, 100}, '{0, 500, 37}, '{1, 0, 16383}, '{0, 2047, 127},
    '{1, 1, 8},   '{0, 16, 0},   '{1, 0, 7},     '{0, 15, 5},
    '{1, 0, 0},   '{0, 1000, 64}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " ratio"}, int'(ref_ratio), e_ratio);
    chk({tag, " mod"},   int'(mod_sel),   e_mod);
    chk({tag, " main"},  int'(main_cnt),  e_main);
    chk({tag, " swal"},  int'(swal_cnt),  e_swal);
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk) ser_dat = b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [18:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic load_pulse();
    @(negedge clk) ser_le = 1'b1;
    repeat (6) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [18:0] ref_word(input int m, input int r);
    return 19'({1'(m), 14'(r), 1'b1});
  endfunction

  function automatic logic [18:0] main_word(input int m, input int s);
    return {11'(m), 7'(s), 1'b0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 reset");
    chk("R1 fast_lock", int'(fast_lock), 0);
    chk("R1 err", int'(cfg_err), 0);

    for (int v = 0; v < NV; v++) begin
      int  e0;
      bit  bad;
      string tag;
      e0 = err_seen;
      if (VEC[v][0] == 1) begin
        send(ref_word(VEC[v][1], VEC[v][2]), 16);
        bad = VEC[v][2] < 8;
        tag = bad ? "R6 ref reject" : "R3 ref load";
        if (!bad) begin e_mod = VEC[v][1]; e_ratio = VEC[v][2]; end
      end else begin
        send(main_word(VEC[v][1], VEC[v][2]), 19);
        bad = VEC[v][1] < 16;
        tag = bad ? "R7 main reject" : "R4 main load";
        if (!bad) begin e_main = VEC[v][1]; e_swal = VEC[v][2]; end
      end
      load_pulse();
      chk_all($sformatf("%s R2 v%0d", tag, v));
      chk($sformatf("%s err pulses v%0d", tag, v), err_seen - e0, bad ? 1 : 0);
    end

    // R5: shifting without a load changes nothing
    send(ref_word(1, 4321), 16);
    repeat (4) @(negedge clk);
    chk_all("R5 no load");

    // R9: leading junk bits ignored
    send(19'h7FFFF, 7);
    send(ref_word(0, 9000), 16);
    load_pulse();
    e_mod = 0; e_ratio = 9000;
    chk_all("R9 ref after junk");
    send(19'h55555, 5);
    send(main_word(300, 99), 19);
    load_pulse();
    e_main = 300; e_swal = 99;
    chk_all("R9 main after junk");

    // R8: fast-lock follows the strobe two edges later
    @(negedge clk) ser_le = 1'b1;
    @(negedge clk) chk("R8 fast_lock after 1 edge", int'(fast_lock), 0);
    @(negedge clk) chk("R8 fast_lock after 2 edges", int'(fast_lock), 1);
    ser_le = 1'b0;
    @(negedge clk) chk("R8 fast_lock held", int'(fast_lock), 1);
    @(negedge clk) chk("R8 fast_lock released", int'(fast_lock), 0);
    repeat (3) @(negedge clk);
    chk_all("R8 reload same word");

    finish_run();
  end
endmodule